// File: doc/BRIEF.md
# OR-Merged Multi-Master Write Data Path

Several requesters share one write channel into a word-wide memory. Each requester has a small driver. The driver accepts one write job at a time, raises a call strobe towards a hub, and waits until the hub acknowledges it by returning its tag. On the cycle after that acknowledge, and only on that cycle, the driver puts its write word and byte mask on its lane. On every other cycle it holds both at zero.

Because idle lanes are zero, the controller does not select or match tags on the data side. It ORs every lane together and writes the result into memory. The byte mask is active-low: a zero bit writes the matching byte and a one bit keeps it. A job comes in one of two modes. A full-word job clears the whole mask. A byte-select job takes active-high selects and inverts them into the mask.

The hub acknowledges at most one caller per cycle, with a fixed priority. It registers the caller's address at the same edge, so the address arrives at the memory together with the delayed data. A combinational read port lets the stored words be inspected. The per-lane outputs and the acknowledge are also brought out as ports for observation.

Top module: `orw_write_path`

## Requirements
- R1: After reset every driver is ready, no acknowledge is raised, all lanes are zero and every memory word reads zero.
- R2: A driver puts its word and mask on its lane in exactly the cycle after the cycle in which the acknowledge carries its own tag, and in no other cycle.
- R3: Outside its data cycle, a lane drives all-zero data and mask, so at most one lane is nonzero in any cycle.
- R4: The hub acknowledges at most one calling driver per cycle. The lowest-numbered caller wins, and the returned tag equals that driver's index (0, 1, 2).
- R5: Mask bit b covers data bits 8b+7 down to 8b. A mask bit at 0 writes that byte; a mask bit at 1 leaves the stored byte unchanged.
- R6: A full-word job (req_full=1) drives an all-zero mask, so all eight bytes are written, whatever its select bits hold.
- R7: A byte-select job (req_full=0) drives the bitwise inverse of its selects as the mask. Selects of all zeros therefore leave memory unchanged.
- R8: The memory writes the OR of all lanes at the address registered with the acknowledge. The new word can be read on rd_data from the cycle after the data cycle.
- R9: A driver keeps calling until its own tag is acknowledged, and req_ready stays low from the accepting edge until its data cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_MST | Per-driver job strobe, taken when req_ready is high |
| req_full | input | N_MST | Per-driver mode: 1 full word, 0 byte select |
| req_addr | input | N_MST*ADDR_W | Per-driver word address |
| req_data | input | N_MST*DATA_W | Per-driver write word |
| req_sel | input | N_MST*DATA_W/8 | Per-driver active-high byte selects |
| req_ready | output | N_MST | Driver idle and able to take a job |
| grant_valid | output | 1 | Hub acknowledges a caller this cycle |
| grant_tag | output | TAG_W | Tag (index) of the acknowledged driver |
| lane_data | output | N_MST*DATA_W | Per-driver data lanes before the OR |
| lane_mask | output | N_MST*DATA_W/8 | Per-driver active-low mask lanes before the OR |
| rd_addr | input | ADDR_W | Inspection read address |
| rd_data | output | DATA_W | Word stored at rd_addr |

## Verification
The assertions rely on the environment offering jobs only through req_valid. They also rely on one property of the design itself: a driver leaves its calling state only on an acknowledge that carries its own tag. Only under that condition does the zero-when-idle rule make the OR merge safe. The stimulus raises req_valid only at a falling edge where req_ready is high, and holds it for a single cycle. Every job it sends has a nonzero word or a nonzero mask, so each data cycle can be seen on the lanes. Jobs are launched together on all three drivers and aimed at a small set of addresses, so that priority order, waiting callers and overlapping byte writes all occur. Every data cycle is compared against the acknowledge seen one cycle earlier.

// File: rtl/orw_pkg.sv
// Shared types for the OR-merged write path.
// Assumes: nothing beyond the SystemVerilog basics.
package orw_pkg;

    // Driver sequence: idle -> calling the hub -> one data cycle -> idle.
    typedef enum logic [1:0] {
        DRV_IDLE = 2'd0,
        DRV_CALL = 2'd1,
        DRV_DATA = 2'd2
    } drv_state_e;

endpackage

// File: rtl/orw_master.sv
// Per-requester write driver. Takes one job and calls the hub until the
// acknowledge carries MY_TAG. It then drives its word and active-low mask
// for exactly one cycle and holds its lane at zero at all other times.
// Assumes: the hub acknowledges combinationally while call is high.
module orw_master
    import orw_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 2,
    parameter int MY_TAG = 0,
    parameter int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_full,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [MASK_W-1:0] req_sel,
    output logic              req_ready,
    output logic              call,
    output logic [ADDR_W-1:0] call_addr,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    output logic [DATA_W-1:0] dat_w,
    output logic [MASK_W-1:0] dat_wm
);

    drv_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [MASK_W-1:0] mask_q;
    logic              ack_mine;

    // Recognise an acknowledge addressed to this driver.
    always_comb begin
        ack_mine = ack_valid && (ack_tag == TAG_W'(MY_TAG));
    end

    // Job capture and the idle/call/data sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRV_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                DRV_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        data_q  <= req_data;
                        mask_q  <= req_full ? '0 : ~req_sel;
                        state_q <= DRV_CALL;
                    end
                end
                DRV_CALL: begin
                    if (ack_mine) begin
                        state_q <= DRV_DATA;
                    end
                end
                default: begin
                    state_q <= DRV_IDLE;
                end
            endcase
        end
    end

    // Handshake outputs and a lane that is zero outside the data cycle.
    always_comb begin
        req_ready = (state_q == DRV_IDLE);
        call      = (state_q == DRV_CALL);
        call_addr = addr_q;
        dat_w     = (state_q == DRV_DATA) ? data_q : '0;
        dat_wm    = (state_q == DRV_DATA) ? mask_q : '0;
    end

    AST_CALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (call && !ack_mine) |=> call); // R9
    AST_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (call && ack_mine) |=> (!call && !req_ready)); // R2
    AST_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(call && ack_mine) |-> (dat_w == '0 && dat_wm == '0)); // R3

endmodule

// File: rtl/orw_hub.sv
// Fixed-priority hub for the callers. The lowest-index caller is
// acknowledged in the same cycle with its index as tag. The granted address
// is registered so it arrives together with the data cycle.
// Assumes: each driver's call stays high until it is acknowledged.
module orw_hub #(
    parameter int N_MST  = 3,
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST-1:0]        call,
    input  logic [N_MST*ADDR_W-1:0] call_addr,
    output logic                    ack_valid,
    output logic [TAG_W-1:0]        ack_tag,
    output logic                    wr_go,
    output logic [ADDR_W-1:0]       wr_addr
);

    logic [ADDR_W-1:0] addr_sel;

    // Priority pick: the loop runs downwards so the lowest index wins.
    always_comb begin
        ack_valid = 1'b0;
        ack_tag   = '0;
        addr_sel  = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (call[i]) begin
                ack_valid = 1'b1;
                ack_tag   = TAG_W'(i);
                addr_sel  = call_addr[i*ADDR_W +: ADDR_W];
            end
        end
    end

    // Delay the write enable and address by one cycle to meet the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_go   <= 1'b0;
            wr_addr <= '0;
        end else begin
            wr_go   <= ack_valid;
            wr_addr <= addr_sel;
        end
    end

    AST_WR_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> wr_go); // R8
    AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> !wr_go); // R8
    AST_ACK_HAS_CALLER: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (call != '0)); // R4

endmodule

// File: rtl/orw_mem.sv
// Controller side: ORs all data and mask lanes and writes the merged word
// with an active-low byte mask. It does no tag matching. A combinational
// port reads a stored word.
// Assumes: every lane that is not in its data cycle is zero.
module orw_mem #(
    parameter int N_MST  = 3,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6,
    parameter int MASK_W = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST*DATA_W-1:0] lane_data,
    input  logic [N_MST*MASK_W-1:0] lane_mask,
    input  logic                    wr_go,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] merged_data;
    logic [MASK_W-1:0] merged_mask;

    // Wired-OR merge of every lane.
    always_comb begin
        merged_data = '0;
        merged_mask = '0;
        for (int i = 0; i < N_MST; i++) begin
            merged_data = merged_data | lane_data[i*DATA_W +: DATA_W];
            merged_mask = merged_mask | lane_mask[i*MASK_W +: MASK_W];
        end
    end

    // Clear on reset, then byte-masked write where the mask bit is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else if (wr_go) begin
            for (int b = 0; b < MASK_W; b++) begin
                if (!merged_mask[b]) begin
                    mem_q[wr_addr][8*b +: 8] <= merged_data[8*b +: 8];
                end
            end
        end
    end

    // Inspection read.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |-> (merged_data == '0 && merged_mask == '0)); // R3

endmodule

// File: rtl/orw_write_path.sv
// Top: N_MST write drivers, one priority hub and the OR-merging memory.
// Lanes and the acknowledge are brought out for observation.
// Assumes: req_valid is raised for a driver only while its req_ready is high.
module orw_write_path #(
    parameter int N_MST  = 3,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6,
    parameter int MASK_W = DATA_W / 8,
    parameter int TAG_W  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST-1:0]        req_valid,
    input  logic [N_MST-1:0]        req_full,
    input  logic [N_MST*ADDR_W-1:0] req_addr,
    input  logic [N_MST*DATA_W-1:0] req_data,
    input  logic [N_MST*MASK_W-1:0] req_sel,
    output logic [N_MST-1:0]        req_ready,
    output logic                    grant_valid,
    output logic [TAG_W-1:0]        grant_tag,
    output logic [N_MST*DATA_W-1:0] lane_data,
    output logic [N_MST*MASK_W-1:0] lane_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);

    logic [N_MST-1:0]        call;
    logic [N_MST*ADDR_W-1:0] call_addr;
    logic                    wr_go;
    logic [ADDR_W-1:0]       wr_addr;
    logic [N_MST-1:0]        lane_busy;

    for (genvar i = 0; i < N_MST; i++) begin : g_drv
        orw_master #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .TAG_W  (TAG_W),
            .MY_TAG (i),
            .MASK_W (MASK_W)
        ) u_drv (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[i]),
            .req_full  (req_full[i]),
            .req_addr  (req_addr[i*ADDR_W +: ADDR_W]),
            .req_data  (req_data[i*DATA_W +: DATA_W]),
            .req_sel   (req_sel[i*MASK_W +: MASK_W]),
            .req_ready (req_ready[i]),
            .call      (call[i]),
            .call_addr (call_addr[i*ADDR_W +: ADDR_W]),
            .ack_valid (grant_valid),
            .ack_tag   (grant_tag),
            .dat_w     (lane_data[i*DATA_W +: DATA_W]),
            .dat_wm    (lane_mask[i*MASK_W +: MASK_W])
        );

        // Lane activity flag used only by the overlap check.
        always_comb begin
            lane_busy[i] = (lane_data[i*DATA_W +: DATA_W] != '0) ||
                           (lane_mask[i*MASK_W +: MASK_W] != '0);
        end
    end

    orw_hub #(
        .N_MST  (N_MST),
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W)
    ) u_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .call      (call),
        .call_addr (call_addr),
        .ack_valid (grant_valid),
        .ack_tag   (grant_tag),
        .wr_go     (wr_go),
        .wr_addr   (wr_addr)
    );

    orw_mem #(
        .N_MST  (N_MST),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_data (lane_data),
        .lane_mask (lane_mask),
        .wr_go     (wr_go),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_busy)); // R3
    AST_LANE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_busy != '0) |-> wr_go); // R2

endmodule

// File: tb/tb_orw_write_path.sv
`timescale 1ns/1ps
module tb_orw_write_path;

    localparam int NM = 3;
    localparam int DW = 64;
    localparam int AW = 6;
    localparam int MW = DW / 8;
    localparam int TW = 2;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [MW-1:0] m;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     req_valid = '0;
    logic [NM-1:0]     req_full = '0;
    logic [AW-1:0]     b_addr [NM];
    logic [DW-1:0]     b_data [NM];
    logic [MW-1:0]     b_sel  [NM];
    logic [NM*AW-1:0]  req_addr;
    logic [NM*DW-1:0]  req_data;
    logic [NM*MW-1:0]  req_sel;
    logic [NM-1:0]     req_ready;
    logic              grant_valid;
    logic [TW-1:0]     grant_tag;
    logic [NM*DW-1:0]  lane_data;
    logic [NM*MW-1:0]  lane_mask;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;

    int total = 0;
    int bad = 0;
    exp_t expq [NM][$];
    int ack_log [$];
    logic [DW-1:0] model [1 << AW];
    logic pv = 1'b0;
    int ptag = 0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < NM; i++) begin : g_flat
        assign req_addr[i*AW +: AW] = b_addr[i];
        assign req_data[i*DW +: DW] = b_data[i];
        assign req_sel[i*MW +: MW]  = b_sel[i];
    end

    orw_write_path dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_full(req_full),
        .req_addr(req_addr), .req_data(req_data), .req_sel(req_sel),
        .req_ready(req_ready), .grant_valid(grant_valid), .grant_tag(grant_tag),
        .lane_data(lane_data), .lane_mask(lane_mask),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: hand one job to driver m and push the expected lane content.
    task automatic issue(input int m, input bit full, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [MW-1:0] s);
        exp_t e;
        @(negedge clk);
        while (!req_ready[m]) @(negedge clk);
        b_addr[m] = a;
        b_data[m] = d;
        b_sel[m]  = s;
        req_full[m] = full;
        req_valid[m] = 1'b1;
        e.a = a;
        e.d = d;
        e.m = full ? '0 : ~s;   // R6 full word clears mask, R7 inverted selects
        expq[m].push_back(e);
        @(negedge clk);
        req_valid[m] = 1'b0;
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    // Monitor: compare each data cycle against the acknowledge one cycle back.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NM-1:0] act;
            logic [NM-1:0] exp_act;
            for (int i = 0; i < NM; i++)
                act[i] = (lane_data[i*DW +: DW] != '0) || (lane_mask[i*MW +: MW] != '0);
            exp_act = pv ? NM'(1 << ptag) : '0;
            if (act != '0 || exp_act != '0)
                check(act == exp_act, "R2 lane timing", DW'(act), DW'(exp_act));
            if (act != '0)
                check($countones(act) <= 1, "R3 single lane", DW'(act), DW'(0));
            for (int i = 0; i < NM; i++) begin
                if (act[i]) begin
                    if (expq[i].size() == 0) begin
                        check(1'b0, "R2 unexpected data cycle", DW'(i), DW'(0));
                    end else begin
                        exp_t e;
                        e = expq[i].pop_front();
                        check(lane_data[i*DW +: DW] == e.d, "R8 lane data",
                              lane_data[i*DW +: DW], e.d);
                        check(lane_mask[i*MW +: MW] == e.m, "R6 R7 lane mask",
                              DW'(lane_mask[i*MW +: MW]), DW'(e.m));
                        for (int b = 0; b < MW; b++)    // R5 active-low bytes
                            if (!e.m[b]) model[e.a][8*b +: 8] = e.d[8*b +: 8];
                    end
                end
            end
            if (grant_valid) ack_log.push_back(int'(grant_tag));
            pv   = grant_valid;
            ptag = int'(grant_tag);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < NM; i++) begin
            b_addr[i] = '0; b_data[i] = '0; b_sel[i] = '0;
        end
        for (int w = 0; w < (1 << AW); w++) model[w] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(req_ready == '1, "R1 ready", DW'(req_ready), DW'(3'b111));
        check(!grant_valid, "R1 no grant", DW'(grant_valid), DW'(0));
        check(lane_data == '0 && lane_mask == '0, "R1 lanes zero",
              DW'(lane_mask), DW'(0));
        read_word(6'd0, v);  check(v == '0, "R1 mem word 0", v, '0);
        read_word(6'd63, v); check(v == '0, "R1 mem word 63", v, '0);

        // R6 full word, selects ignored
        issue(0, 1'b1, 6'd3, 64'h1111_2222_3333_4444, 8'h00);
        drain();
        read_word(6'd3, v);
        check(v == 64'h1111_2222_3333_4444, "R6 full write", v, 64'h1111_2222_3333_4444);

        // R5 active-low mask: selects 0x0F write the low four bytes
        issue(1, 1'b0, 6'd3, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
        drain();
        read_word(6'd3, v);
        check(v == 64'h1111_2222_CCCC_DDDD, "R5 byte mask", v, 64'h1111_2222_CCCC_DDDD);

        // R7 empty selects leave memory unchanged
        issue(2, 1'b0, 6'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
        drain();
        read_word(6'd3, v);
        check(v == 64'h1111_2222_CCCC_DDDD, "R7 no bytes selected", v, 64'h1111_2222_CCCC_DDDD);

        // R4 priority and R9 waiting callers
        ack_log.delete();
        fork
            issue(2, 1'b1, 6'd10, 64'h0000_0000_0000_2222, 8'h00);
            issue(1, 1'b1, 6'd11, 64'h0000_0000_0000_1111, 8'h00);
            issue(0, 1'b1, 6'd12, 64'h0000_0000_0000_0AAA, 8'h00);
        join
        check(req_ready == '0, "R9 busy after accept", DW'(req_ready), DW'(0));
        @(negedge clk);
        check(req_ready[2] == 1'b0, "R9 lowest priority still waiting",
              DW'(req_ready[2]), DW'(0));
        drain();
        check(ack_log.size() == 3, "R4 grant count", DW'(ack_log.size()), DW'(3));
        if (ack_log.size() == 3) begin
            check(ack_log[0] == 0, "R4 first grant", DW'(ack_log[0]), DW'(0));
            check(ack_log[1] == 1, "R4 second grant", DW'(ack_log[1]), DW'(1));
            check(ack_log[2] == 2, "R4 third grant", DW'(ack_log[2]), DW'(2));
        end

        // R8 same address from two drivers: index 0 lands first, 2 overrides
        fork
            issue(2, 1'b0, 6'd20, 64'h9999_9999_9999_9999, 8'hF0);
            issue(0, 1'b1, 6'd20, 64'h5555_5555_5555_5555, 8'h00);
        join
        drain();
        read_word(6'd20, v);
        check(v == 64'h9999_9999_5555_5555, "R8 ordered overlap", v, 64'h9999_9999_5555_5555);

        // Mixed traffic on all drivers into a small address set
        fork
            for (int k = 0; k < 20; k++)
                issue(0, 1'($urandom % 2), AW'($urandom % 8),
                      {32'($urandom), 32'($urandom)} | 64'h1, MW'($urandom));
            for (int k = 0; k < 20; k++)
                issue(1, 1'($urandom % 2), AW'($urandom % 8),
                      {32'($urandom), 32'($urandom)} | 64'h1, MW'($urandom));
            for (int k = 0; k < 20; k++)
                issue(2, 1'($urandom % 2), AW'($urandom % 8),
                      {32'($urandom), 32'($urandom)} | 64'h1, MW'($urandom));
        join
        drain();

        // R8 whole memory against the byte-masked reference
        for (int a = 0; a < (1 << AW); a++) begin
            read_word(AW'(a), v);
            check(v == model[a], "R8 memory compare", v, model[a]);
        end
        for (int i = 0; i < NM; i++)
            check(expq[i].size() == 0, "R2 all jobs written",
                  DW'(expq[i].size()), DW'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule